// File: doc/BRIEF.md
# Four-Pin GPIO Port Register Bank

This block is the register bank behind a small general-purpose I/O port. A byte-wide register access interface (a two-bit register pointer, a write strobe with write data, a read request and a registered read byte) reaches four byte registers. Three of them are storage: the drive level of each pin, a per-pin read inversion mask and a per-pin direction mask. The fourth is a read-only view of the live pin levels. The bank produces a drive value and a drive enable for each pin. The serial bus engine in front of it and the pad cells behind it are out of scope. Each pin is modelled as separate in, out and output-enable signals.

Direction uses 1 for input, with the driver off, and 0 for output. After reset every pin is an input. A read of the pin view samples the pins in the cycle of the read request and applies the inversion mask to every pin, whatever its direction. A read of the drive register returns the stored value, not the level seen on the pin.

Top module: `gpio_port_bank`

## Requirements
- R1: After reset, reads return 0xFF from the drive register (pointer 1), 0x00 from the inversion register (pointer 2) and 0xFF from the direction register (pointer 3). pin_oe is 0000 and pin_out is 0000.
- R2: A write to pointer 3 sets pin_oe[i] to the inverse of written bit i. The new enables appear in the cycle after the write strobe.
- R3: A pin whose direction bit is 1 is not driven: pin_oe[i] is 0 and pin_out[i] is 0 whatever the drive register holds. A pin whose direction bit is 0 drives drive-register bit i on pin_out[i].
- R4: A write to pointer 1 shows on pin_out of the output pins in the cycle after the write strobe.
- R5: A read of pointer 0 returns all ones in bits 7:4. Bits 3:0 are pin_in as sampled at the read-request edge, whether each pin is an input or an output.
- R6: In a read of pointer 0, inversion bit i set to 1 inverts bit i. Inversion bit i at 0 passes bit i unchanged.
- R7: A read of pointer 1 returns the stored drive byte, not the pin levels on pin_in.
- R8: A write to pointer 0 has no effect. pin_out, pin_oe and the contents of all other registers stay unchanged.
- R9: Bits 7:4 of pointers 1, 2 and 3 store any written value and read it back unchanged. They have no effect on any pin.
- R10: rd_data changes only in the cycle after a read request. rd_data then holds that value until the next request, even when pin_in changes.
- R11: A read and a write to the same register in the same cycle return the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 2 | Register pointer: 0 pin view, 1 drive, 2 inversion, 3 direction |
| wr_en | input | 1 | Write strobe for the pointed register |
| wr_data | input | 8 | Write byte |
| rd_req | input | 1 | Read request for the pointed register |
| rd_data | output | 8 | Read byte, updated the cycle after rd_req |
| pin_in | input | 4 | Live pin levels |
| pin_out | output | 4 | Pin drive values |
| pin_oe | output | 4 | Pin drive enables, 1 = driving |

## Verification
The bench drives pin_in to differ from the stored drive byte. A design that read back the pins for pointer 1 would then return the wrong byte. Pin-view reads are taken while some pins are outputs and with the inversion mask set. An implementation that gated inversion or sampling by direction would misreport those pins. The bench writes to the read-only pointer and to the upper nibbles of the storage registers, then checks that pins and neighbouring registers did not move. It also reads and writes one register in the same cycle, and changes pin_in right after a request, to catch a read path that is not a single sample or that passes write data through.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
   typedef enum logic [1:0] {
      SEL_PINS   = 2'd0,
      SEL_DRIVE  = 2'd1,
      SEL_INVERT = 2'd2,
      SEL_DIR    = 2'd3
   } reg_sel_e;

   localparam int NUM_REGS = 4;
endpackage

// File: rtl/gpio_byte_reg.sv
module gpio_byte_reg #(
   parameter int           BYTE_W    = 8,
   parameter logic [BYTE_W-1:0] RST_VAL = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [BYTE_W-1:0] d,
   output logic [BYTE_W-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n)  q <= RST_VAL;
      else if (we) q <= d;
   end
endmodule

// File: rtl/gpio_pin_drv.sv
module gpio_pin_drv (
   input  logic drive_bit,
   input  logic dir_bit,
   output logic pad_out,
   output logic pad_oe
);
   always_comb begin
      pad_oe  = ~dir_bit;
      pad_out = drive_bit & ~dir_bit;
   end
endmodule

// File: rtl/gpio_read_port.sv
module gpio_read_port #(
   parameter int BYTE_W = 8,
   parameter int PIN_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_req,
   input  logic [1:0]        sel,
   input  logic [PIN_W-1:0]  pins,
   input  logic [BYTE_W-1:0] drive_q,
   input  logic [BYTE_W-1:0] invert_q,
   input  logic [BYTE_W-1:0] dir_q,
   output logic [BYTE_W-1:0] rd_data
);
   import gpio_port_pkg::*;
   localparam int FILL_W = BYTE_W - PIN_W;

   logic [BYTE_W-1:0] pin_view;
   logic [BYTE_W-1:0] sel_byte;

   always_comb begin
      pin_view = {{FILL_W{1'b1}}, pins ^ invert_q[PIN_W-1:0]};
      unique case (reg_sel_e'(sel))
         SEL_PINS:   sel_byte = pin_view;
         SEL_DRIVE:  sel_byte = drive_q;
         SEL_INVERT: sel_byte = invert_q;
         default:    sel_byte = dir_q;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      rd_data <= '0;
      else if (rd_req) rd_data <= sel_byte;
   end
endmodule

// File: rtl/gpio_port_bank.sv
module gpio_port_bank #(
   parameter int BYTE_W = 8,
   parameter int PIN_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        reg_sel,
   input  logic              wr_en,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic              rd_req,
   output logic [BYTE_W-1:0] rd_data,
   input  logic [PIN_W-1:0]  pin_in,
   output logic [PIN_W-1:0]  pin_out,
   output logic [PIN_W-1:0]  pin_oe
);
   import gpio_port_pkg::*;

   localparam logic [BYTE_W-1:0] ONES  = {BYTE_W{1'b1}};
   localparam logic [BYTE_W-1:0] ZEROS = {BYTE_W{1'b0}};

   if (PIN_W < 1 || PIN_W >= BYTE_W) begin : g_bad_width
      $error("gpio_port_bank: PIN_W must be in 1..BYTE_W-1");
   end
   if (NUM_REGS != 4) begin : g_bad_regs
      $error("gpio_port_bank: pointer decode assumes four registers");
   end

   logic [BYTE_W-1:0] reg_q [1:NUM_REGS-1];

   for (genvar k = 1; k < NUM_REGS; k++) begin : g_reg
      localparam logic [BYTE_W-1:0] RV = (k == int'(SEL_INVERT)) ? ZEROS : ONES;
      gpio_byte_reg #(.BYTE_W(BYTE_W), .RST_VAL(RV)) u_reg (
         .clk   (clk),
         .rst_n (rst_n),
         .we    (wr_en && (reg_sel == 2'(k))),
         .d     (wr_data),
         .q     (reg_q[k])
      );
   end

   for (genvar i = 0; i < PIN_W; i++) begin : g_pin
      gpio_pin_drv u_drv (
         .drive_bit (reg_q[SEL_DRIVE][i]),
         .dir_bit   (reg_q[SEL_DIR][i]),
         .pad_out   (pin_out[i]),
         .pad_oe    (pin_oe[i])
      );
   end

   gpio_read_port #(.BYTE_W(BYTE_W), .PIN_W(PIN_W)) u_rd (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_req   (rd_req),
      .sel      (reg_sel),
      .pins     (pin_in),
      .drive_q  (reg_q[SEL_DRIVE]),
      .invert_q (reg_q[SEL_INVERT]),
      .dir_q    (reg_q[SEL_DIR]),
      .rd_data  (rd_data)
   );
endmodule

// File: rtl/gpio_port_bank_chk.sv
module gpio_port_bank_chk #(
   parameter int BYTE_W = 8,
   parameter int PIN_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        reg_sel,
   input logic              wr_en,
   input logic [BYTE_W-1:0] wr_data,
   input logic              rd_req,
   input logic [BYTE_W-1:0] rd_data,
   input logic [PIN_W-1:0]  pin_in,
   input logic [PIN_W-1:0]  pin_out,
   input logic [PIN_W-1:0]  pin_oe
);
   localparam int FILL_W = BYTE_W - PIN_W;

   assert_dir_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && reg_sel == 2'd3) |=> pin_oe == ~$past(wr_data[PIN_W-1:0]));

   assert_input_undriven_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_out & ~pin_oe) == '0);

   assert_drive_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && reg_sel == 2'd1) |=>
         (pin_out & pin_oe) == ($past(wr_data[PIN_W-1:0]) & pin_oe));

   assert_pin_view_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && reg_sel == 2'd0) |=> rd_data[BYTE_W-1:PIN_W] == {FILL_W{1'b1}});

   assert_ro_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && reg_sel == 2'd0) |=> $stable(pin_out) && $stable(pin_oe));

   assert_read_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_req |=> $stable(rd_data));
endmodule

bind gpio_port_bank gpio_port_bank_chk #(.BYTE_W(BYTE_W), .PIN_W(PIN_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .reg_sel (reg_sel),
   .wr_en   (wr_en),
   .wr_data (wr_data),
   .rd_req  (rd_req),
   .rd_data (rd_data),
   .pin_in  (pin_in),
   .pin_out (pin_out),
   .pin_oe  (pin_oe)
);

// File: tb/tb_gpio_port_bank.sv
module tb_gpio_port_bank;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] reg_sel = '0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic       rd_req = 1'b0;
   logic [7:0] rd_data;
   logic [3:0] pin_in = '0;
   logic [3:0] pin_out;
   logic [3:0] pin_oe;

   int n_run  = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   gpio_port_bank dut (
      .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en),
      .wr_data(wr_data), .rd_req(rd_req), .rd_data(rd_data),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] s, input logic [7:0] d);
      reg_sel = s; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] s, output logic [7:0] v);
      reg_sel = s; rd_req = 1'b1;
      @(negedge clk);
      rd_req = 1'b0;
      v = rd_data;
   endtask

   task automatic t_reset;
      logic [7:0] v;
      chk("R1 oe", {4'h0, pin_oe}, 8'h00);
      chk("R1 out", {4'h0, pin_out}, 8'h00);
      rd(2'd1, v); chk("R1 drive", v, 8'hFF);
      rd(2'd2, v); chk("R1 invert", v, 8'h00);
      rd(2'd3, v); chk("R1 dir", v, 8'hFF);
      pin_in = 4'b1010;
      rd(2'd0, v); chk("R5 pins at reset", v, 8'hFA);
   endtask

   task automatic t_direction;
      wr(2'd3, 8'hF0);
      chk("R2 all out oe", {4'h0, pin_oe}, 8'h0F);
      chk("R3 drive ones", {4'h0, pin_out}, 8'h0F);
      wr(2'd1, 8'hA5);
      chk("R4 new drive", {4'h0, pin_out}, 8'h05);
      wr(2'd3, 8'hF3);
      chk("R2 mixed oe", {4'h0, pin_oe}, 8'h0C);
      chk("R3 inputs low", {4'h0, pin_out}, 8'h04);
   endtask

   task automatic t_readback;
      logic [7:0] v;
      pin_in = 4'b0000;
      rd(2'd1, v); chk("R7 flop not pin", v, 8'hA5);
      pin_in = 4'b0110;
      rd(2'd0, v); chk("R5 pins any dir", v, 8'hF6);
   endtask

   task automatic t_invert;
      logic [7:0] v;
      wr(2'd2, 8'h39);
      rd(2'd2, v); chk("R9 invert upper", v, 8'h39);
      rd(2'd0, v); chk("R6 inverted view", v, 8'hFF);
      pin_in = 4'b1001;
      rd(2'd0, v); chk("R6 inverted view 2", v, 8'hF0);
      wr(2'd2, 8'h00);
   endtask

   task automatic t_upper;
      logic [7:0] v;
      wr(2'd3, 8'h5C);
      rd(2'd3, v); chk("R9 dir upper", v, 8'h5C);
      chk("R9 oe low nibble only", {4'h0, pin_oe}, 8'h03);
      chk("R3 drive on outputs", {4'h0, pin_out}, 8'h01);
      wr(2'd1, 8'h3A);
      rd(2'd1, v); chk("R9 drive upper", v, 8'h3A);
      chk("R4 drive 3A", {4'h0, pin_out}, 8'h02);
   endtask

   task automatic t_ro_write;
      logic [7:0] v;
      wr(2'd0, 8'h00);
      chk("R8 oe kept", {4'h0, pin_oe}, 8'h03);
      chk("R8 out kept", {4'h0, pin_out}, 8'h02);
      rd(2'd1, v); chk("R8 drive kept", v, 8'h3A);
      rd(2'd2, v); chk("R8 invert kept", v, 8'h00);
      rd(2'd3, v); chk("R8 dir kept", v, 8'h5C);
      pin_in = 4'b0011;
      rd(2'd0, v); chk("R8 pins view", v, 8'hF3);
   endtask

   task automatic t_same_cycle;
      logic [7:0] v;
      reg_sel = 2'd2; wr_data = 8'hC3; wr_en = 1'b1; rd_req = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; rd_req = 1'b0;
      chk("R11 old value", rd_data, 8'h00);
      rd(2'd2, v); chk("R11 new stored", v, 8'hC3);
      wr(2'd2, 8'h00);
   endtask

   task automatic t_hold;
      logic [7:0] v;
      pin_in = 4'b0101;
      reg_sel = 2'd0; rd_req = 1'b1;
      @(posedge clk);
      #1 pin_in = 4'b1110; rd_req = 1'b0;
      @(negedge clk);
      chk("R10 single sample", rd_data, 8'hF5);
      repeat (3) @(negedge clk);
      chk("R10 held", rd_data, 8'hF5);
      rd(2'd0, v); chk("R10 next request", v, 8'hFE);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_direction();
      t_readback();
      t_invert();
      t_upper();
      t_ro_write();
      t_same_cycle();
      t_hold();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule